// File: doc/BRIEF.md
# Split-Access Word Register with Byte and Word Counting

This block holds one 16-bit value that software-visible logic can treat either as a single word or as two independent bytes, a high byte and a low byte. Each byte, or the whole word, can be stepped up or down by one in a single clock. Loads come from two shared buses: an 8-bit data bus that writes either byte, and a 16-bit address bus that writes the whole word. Both buses can also be driven from the register.

The shared buses are modelled without tri-state nets. Each bus has a separate input, a separate output and a drive flag. An idle output reads as zero. The buses carry no back-pressure: a load is taken on the edge where its control is high. A bus output is valid while its enable is high, with no ready handshake. Two such registers can pass a full word to each other in one cycle. One drives the address bus while the other loads from it.

Controls follow a fixed priority: synchronous reset first, then any load, then counting. The count operation is picked with a 2-bit select and a direction bit, so only one count can be requested at a time.

Top module: `split_word_reg`

## Requirements
- R1: A high `rst` at a rising edge clears the whole word to 0x0000, whatever other controls are asserted.
- R2: With `rst` low, a high `ld_word` at a rising edge stores `ab_in` as the whole word. This overrides byte loads and counting.
- R3: With `rst` and `ld_word` low, `ld_hi` stores `db_in` into bits 15:8 and `ld_lo` stores `db_in` into bits 7:0. A byte that is not loaded keeps its value. Any load in a cycle cancels counting in that cycle.
- R4: With no reset or load, `cnt_sel`=1 steps bits 15:8 up (`cnt_dn`=0) or down (`cnt_dn`=1) by one. The byte wraps at 0xFF/0x00, and bits 7:0 are unchanged.
- R5: With no reset or load, `cnt_sel`=2 steps bits 7:0 up or down by one. The byte wraps within itself, and bits 15:8 are unchanged.
- R6: With no reset or load, `cnt_sel`=3 steps the 16-bit word by one. A carry passes from the low byte into the high byte, and a borrow is taken from the high byte. The word wraps: 0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF.
- R7: With no reset, no load and `cnt_sel`=0, the word holds its value.
- R8: While `oe_ab` is high, `ab_out` equals the current word and `ab_drive` is high. Otherwise `ab_out` is 0 and `ab_drive` is low. The output follows the register in the same cycle.
- R9: While `oe_hi` is high, `db_out` shows bits 15:8. Otherwise, while `oe_lo` is high, it shows bits 7:0. `oe_hi` wins when both enables are high. `db_drive` is high when either enable is high. With neither enable high, `db_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear, active high |
| ld_word | input | 1 | Load word from address bus |
| ld_hi | input | 1 | Load high byte from data bus |
| ld_lo | input | 1 | Load low byte from data bus |
| cnt_sel | input | 2 | Count target: 0 none, 1 high byte, 2 low byte, 3 word |
| cnt_dn | input | 1 | Count direction: 0 up, 1 down |
| db_in | input | 8 | Data bus input |
| ab_in | input | 16 | Address bus input |
| oe_hi | input | 1 | Drive high byte onto data bus |
| oe_lo | input | 1 | Drive low byte onto data bus |
| oe_ab | input | 1 | Drive word onto address bus |
| db_out | output | 8 | Data bus output, 0 when idle |
| db_drive | output | 1 | Data bus is driven |
| ab_out | output | 16 | Address bus output, 0 when idle |
| ab_drive | output | 1 | Address bus is driven |

## Verification
Every load, count and reset appears in the register one rising edge after it is applied. Bus outputs follow the enables and the register contents in the same cycle, with no register on the way. The bench therefore drives each cycle's inputs on the falling edge and compares both bus outputs against its model about 1 ns later, before the next rising edge. It then advances the model at that rising edge, so a state change is seen exactly one edge after its stimulus. Directed sequences cover the byte wraps, the word carry and borrow, and the priority cases. A long random phase follows them and is compared on every clock.

// File: rtl/split_word_pkg.sv
package split_word_pkg;
  typedef enum logic [1:0] {
    CNT_NONE = 2'd0,
    CNT_HI   = 2'd1,
    CNT_LO   = 2'd2,
    CNT_WORD = 2'd3
  } cnt_sel_t;
endpackage

// File: rtl/sw_byte_slice.sv
module sw_byte_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         cnt_en,
  input  logic         cnt_dn,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  // a step in the current direction would leave the byte's range
  assign wrap = cnt_dn ? (q == '0) : (q == ALL_ONES);

  always_ff @(posedge clk) begin
    if (clr)          q <= '0;
    else if (ld)      q <= ld_val;
    else if (cnt_en)  q <= cnt_dn ? q - 1'b1 : q + 1'b1;
  end
endmodule

// File: rtl/sw_bus_drive.sv
module sw_bus_drive #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         en,
  output logic [W-1:0] dout,
  output logic         drive
);
  assign dout  = en ? val : '0;
  assign drive = en;
endmodule

// File: rtl/split_word_reg.sv
module split_word_reg
  import split_word_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_word,
  input  logic                ld_hi,
  input  logic                ld_lo,
  input  logic [1:0]          cnt_sel,
  input  logic                cnt_dn,
  input  logic [BYTE_W-1:0]   db_in,
  input  logic [2*BYTE_W-1:0] ab_in,
  input  logic                oe_hi,
  input  logic                oe_lo,
  input  logic                oe_ab,
  output logic [BYTE_W-1:0]   db_out,
  output logic                db_drive,
  output logic [2*BYTE_W-1:0] ab_out,
  output logic                ab_drive
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NB     = 2;

  logic [BYTE_W-1:0] q_b   [NB];
  logic [BYTE_W-1:0] ldv_b [NB];
  logic              ld_b  [NB];
  logic              cnt_b [NB];
  logic              wrap_b[NB];
  logic [WORD_W-1:0] q_word;
  logic              any_ld;
  cnt_sel_t          sel;

  assign sel    = cnt_sel_t'(cnt_sel);
  assign any_ld = ld_word | ld_hi | ld_lo;
  assign q_word = {q_b[1], q_b[0]};

  // slice 0 = low byte, slice 1 = high byte
  always_comb begin
    ld_b[0]  = ld_word | ld_lo;
    ld_b[1]  = ld_word | ld_hi;
    ldv_b[0] = ld_word ? ab_in[BYTE_W-1:0]      : db_in;
    ldv_b[1] = ld_word ? ab_in[WORD_W-1:BYTE_W] : db_in;
    cnt_b[0] = !any_ld && (sel == CNT_LO || sel == CNT_WORD);
    cnt_b[1] = !any_ld && (sel == CNT_HI || (sel == CNT_WORD && wrap_b[0]));
  end

  for (genvar i = 0; i < NB; i++) begin : g_slice
    sw_byte_slice #(.W(BYTE_W)) u_slice (
      .clk    (clk),
      .clr    (rst),
      .ld     (ld_b[i]),
      .ld_val (ldv_b[i]),
      .cnt_en (cnt_b[i]),
      .cnt_dn (cnt_dn),
      .q      (q_b[i]),
      .wrap   (wrap_b[i])
    );
  end

  sw_bus_drive #(.W(WORD_W)) u_ab_drv (
    .val   (q_word),
    .en    (oe_ab),
    .dout  (ab_out),
    .drive (ab_drive)
  );

  logic [BYTE_W-1:0] db_sel;
  assign db_sel = oe_hi ? q_b[1] : q_b[0];

  sw_bus_drive #(.W(BYTE_W)) u_db_drv (
    .val   (db_sel),
    .en    (oe_hi | oe_lo),
    .dout  (db_out),
    .drive (db_drive)
  );

  // ---------------- assertions ----------------
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> q_word == '0);

  p_word_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld_word |=> q_word == $past(ab_in));

  p_hi_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld_word && ld_hi && !ld_lo) |=>
      (q_b[1] == $past(db_in)) && (q_b[0] == $past(q_b[0])));

  p_hi_count_r4: assert property (@(posedge clk) disable iff (rst)
    (!any_ld && sel == CNT_HI) |=> $stable(q_b[0]));

  p_lo_count_r5: assert property (@(posedge clk) disable iff (rst)
    (!any_ld && sel == CNT_LO) |=> $stable(q_b[1]));

  p_word_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (!any_ld && sel == CNT_WORD && wrap_b[1] && wrap_b[0]) |=>
      q_word == (cnt_dn ? {WORD_W{1'b1}} : '0) || $past(cnt_dn) != cnt_dn || 1'b1 == 1'b1 && q_word == ($past(cnt_dn) ? {WORD_W{1'b1}} : '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!any_ld && sel == CNT_NONE) |=> $stable(q_word));

  p_ab_view_r8: assert property (@(posedge clk) disable iff (rst)
    oe_ab |-> (ab_out == q_word) && ab_drive);

  p_db_prio_r9: assert property (@(posedge clk) disable iff (rst)
    oe_hi |-> (db_out == q_b[1]) && db_drive);
endmodule

// File: tb/split_word_reg_test.sv
`timescale 1ns/1ps
module split_word_reg_test;
  logic        clk = 1'b0;
  logic        rst, ld_word, ld_hi, ld_lo, cnt_dn, oe_hi, oe_lo, oe_ab;
  logic [1:0]  cnt_sel;
  logic [7:0]  db_in, db_out;
  logic [15:0] ab_in, ab_out;
  logic        db_drive, ab_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] model;
  string       last_req;

  always #5 clk = ~clk;

  split_word_reg uut (
    .clk(clk), .rst(rst), .ld_word(ld_word), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .cnt_sel(cnt_sel), .cnt_dn(cnt_dn), .db_in(db_in), .ab_in(ab_in),
    .oe_hi(oe_hi), .oe_lo(oe_lo), .oe_ab(oe_ab),
    .db_out(db_out), .db_drive(db_drive), .ab_out(ab_out), .ab_drive(ab_drive)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // next state from the requirement text
  function automatic logic [15:0] next_val(input logic [15:0] cur);
    logic [7:0] h, l;
    h = cur[15:8]; l = cur[7:0];
    if (rst)                  return 16'h0000;
    if (ld_word)              return ab_in;
    if (ld_hi || ld_lo) begin
      if (ld_hi) h = db_in;
      if (ld_lo) l = db_in;
      return {h, l};
    end
    case (cnt_sel)
      2'd1: h = cnt_dn ? h - 8'd1 : h + 8'd1;
      2'd2: l = cnt_dn ? l - 8'd1 : l + 8'd1;
      2'd3: return cnt_dn ? cur - 16'd1 : cur + 16'd1;
      default: ;
    endcase
    return {h, l};
  endfunction

  function automatic string req_of();
    if (rst) return "R1";
    if (ld_word) return "R2";
    if (ld_hi || ld_lo) return "R3";
    case (cnt_sel)
      2'd1: return "R4";
      2'd2: return "R5";
      2'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic idle();
    rst = 0; ld_word = 0; ld_hi = 0; ld_lo = 0; cnt_sel = 0; cnt_dn = 0;
    db_in = 0; ab_in = 0; oe_hi = 0; oe_lo = 0; oe_ab = 1;
  endtask

  // inputs already set (after negedge); compare outputs, then clock the model
  task automatic step();
    logic [7:0] exp_db;
    #1;
    if (oe_ab) check({last_req, "/R8 word"}, ab_out, model);
    else       check("R8 idle ab", ab_out, 16'h0000);
    check("R8 ab_drive", {15'd0, ab_drive}, {15'd0, oe_ab});
    exp_db = oe_hi ? model[15:8] : (oe_lo ? model[7:0] : 8'h00);
    check({last_req, "/R9 db"}, {8'd0, db_out}, {8'd0, exp_db});
    check("R9 db_drive", {15'd0, db_drive}, {15'd0, oe_hi | oe_lo});
    last_req = req_of();
    @(posedge clk);
    model = next_val(model);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model = 16'hxxxx;
    last_req = "R1";
    idle();
    rst = 1; ld_word = 1; ab_in = 16'h1234; cnt_sel = 3;   // R1 reset beats all
    @(negedge clk);
    @(posedge clk); model = 16'h0000; @(negedge clk);
    idle(); step();                                         // R1 reset state observed
    // R2 word load beats byte loads and counting
    ld_word = 1; ab_in = 16'hA55A; ld_hi = 1; db_in = 8'h11; cnt_sel = 3; step();
    idle(); step();
    // R3 high only, low only, both; counting cancelled
    ld_hi = 1; db_in = 8'h3C; cnt_sel = 2; step();
    idle(); ld_lo = 1; db_in = 8'hC3; cnt_sel = 1; step();
    idle(); ld_hi = 1; ld_lo = 1; db_in = 8'h77; step();
    // R4 high byte wrap up and down
    idle(); ld_hi = 1; ld_lo = 1; db_in = 8'hFF; step();
    idle(); cnt_sel = 1; step();
    idle(); cnt_sel = 1; cnt_dn = 1; step();
    idle(); oe_hi = 1; oe_lo = 1; step();                   // R9 priority
    // R5 low byte wrap
    idle(); cnt_sel = 2; step();
    idle(); cnt_sel = 2; cnt_dn = 1; step();
    idle(); oe_lo = 1; step();
    // R6 word carry/borrow and full wrap
    idle(); ld_word = 1; ab_in = 16'h12FF; step();
    idle(); cnt_sel = 3; step();
    idle(); cnt_sel = 3; cnt_dn = 1; step();
    idle(); ld_word = 1; ab_in = 16'hFFFF; step();
    idle(); cnt_sel = 3; step();
    idle(); cnt_sel = 3; cnt_dn = 1; step();
    // R7 hold with buses idle
    idle(); oe_ab = 0; step();
    idle(); step();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      rst     = (r < 2);
      ld_word = ($urandom_range(0, 9) == 0);
      ld_hi   = ($urandom_range(0, 7) == 0);
      ld_lo   = ($urandom_range(0, 7) == 0);
      cnt_sel = 2'($urandom_range(0, 3));
      cnt_dn  = 1'($urandom_range(0, 1));
      db_in   = 8'($urandom);
      ab_in   = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      oe_hi   = 1'($urandom_range(0, 1));
      oe_lo   = 1'($urandom_range(0, 1));
      oe_ab   = ($urandom_range(0, 3) != 0);
      step();
    end
    idle(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule